// File: doc/BRIEF.md
# Real-Time Counter Timebase

This block is the timing core of a low-power real-time counter. A slow tick enable, qualified by a run control and by the debug-halt policy, advances a 15-bit pre-counter. The pre-counter then produces the advance strobe for a 32-bit main counter in one of two ways. In the first, a power-of-two divider picks one advance in every 2^k, with k from 0 to 15. In the second, the main counter advances when the pre-counter equals the low 15 bits of the channel 0 compare value.

Either counter can be set to wrap to zero on a compare value. The pre-counter wraps on channel 0 and the main counter wraps on channel 1. Software can load either counter at any time. The block also drives a 32-bit combined word that joins the low main-counter bits to the pre-counter value. It puts out a one-cycle main tick strobe for the capture/compare channels downstream. The configuration bus is captured into a register only on a write strobe, and that register has defined reset defaults.

Top module: `rtc_timebase`

## Requirements
- R1: After reset, both counters and the combined word read zero and cnt_tick is low. The captured configuration is: divide select 5 (divide by 32), prescaler tick mode, both wraps off, and counting frozen during debug halt.
- R2: In prescaler mode (cfg_match_mode=0) the pre-counter rises by one on each qualified advance. With divide select k, the main counter rises by one on the advance at which the low k bits of the pre-counter are all ones, so it advances once per 2^k advances. k=0 advances it on every advance and k=15 when the pre-counter is 32767.
- R3: In match mode (cfg_match_mode=1) the main counter rises by one on an advance at which the pre-counter equals cmp0[14:0].
- R4: With pre-counter wrap on (cfg_pre_wrap=1), an advance at which the pre-counter equals cmp0[14:0] sets it to zero instead of incrementing it.
- R5: With counter wrap on (cfg_cnt_wrap=1), a main tick at which the main counter equals cmp1 sets it to zero instead of incrementing it.
- R6: comb_q[31:15] equals cnt_q[16:0] and comb_q[14:0] equals pre_q.
- R7: While dbg_halt is high, both counters hold if cfg_dbg_run=0 and keep counting if cfg_dbg_run=1.
- R8: When run_en is low, or tick_en is low, both counters hold their values.
- R9: A load (pre_ld or cnt_ld) sets that counter to its load value at the next edge, taking priority over an increment or wrap in the same cycle.
- R10: cnt_tick is high for exactly the cycles in which a main-counter advance is due, and the main counter shows the new value after the following edge.
- R11: Configuration inputs take effect only in a cycle with cfg_wr high; changing them without cfg_wr has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Global counting enable |
| tick_en | input | 1 | Low-frequency tick enable, one cycle per slow tick |
| dbg_halt | input | 1 | Debug halt indication |
| cfg_wr | input | 1 | Captures the configuration inputs |
| cfg_div_sel | input | 4 | Divider select k, divide by 2^k |
| cfg_match_mode | input | 1 | 0: divider ticks, 1: channel 0 match ticks |
| cfg_pre_wrap | input | 1 | Pre-counter wraps on channel 0 compare |
| cfg_cnt_wrap | input | 1 | Main counter wraps on channel 1 compare |
| cfg_dbg_run | input | 1 | Keep counting during debug halt |
| cmp0 | input | 32 | Channel 0 compare value |
| cmp1 | input | 32 | Channel 1 compare value |
| pre_ld | input | 1 | Load strobe for the pre-counter |
| pre_ld_val | input | 15 | Pre-counter load value |
| cnt_ld | input | 1 | Load strobe for the main counter |
| cnt_ld_val | input | 32 | Main counter load value |
| pre_q | output | 15 | Pre-counter value |
| cnt_q | output | 32 | Main counter value |
| comb_q | output | 32 | Combined main/pre-counter word |
| cnt_tick | output | 1 | Main-counter advance strobe |

## Verification
The bound checker checks on every cycle the local rules: both wrap-to-zero events, that counters hold when disabled or frozen by a debug halt, that loads win over increments, and that the main counter changes only when cnt_tick is high or a load occurs. Only the bench scenarios can show the rates and the reset defaults. These cover the divide-by-2^k spacing for several settings, the match-mode period set by the channel 0 compare, and the divide-by-32 behaviour straight out of reset. They also show that configuration changes without the write strobe do nothing.

// File: rtl/rtc_timebase_pkg.sv
package rtc_timebase_pkg;

   localparam int DIV_SEL_W = 4;

   typedef struct packed {
      logic [DIV_SEL_W-1:0] div_sel;
      logic                 match_mode;
      logic                 pre_wrap;
      logic                 cnt_wrap;
      logic                 dbg_run;
   } tb_cfg_t;

   // divide by 32, prescaler ticks, no wraps, freeze while halted
   localparam tb_cfg_t CFG_RESET = '{
      div_sel:    DIV_SEL_W'(5),
      match_mode: 1'b0,
      pre_wrap:   1'b0,
      cnt_wrap:   1'b0,
      dbg_run:    1'b0
   };

endpackage

// File: rtl/rtc_prediv.sv
module rtc_prediv #(
   parameter int PRE_W = 15,
   parameter int SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             match_mode,
   input  logic             wrap_en,
   input  logic [PRE_W-1:0] cmp_lo,
   input  logic             ld,
   input  logic [PRE_W-1:0] ld_val,
   output logic [PRE_W-1:0] pre_q,
   output logic             main_tick
);

   localparam int MAX_DIV_BITS = (1 << SEL_W) - 1;

   if (PRE_W < MAX_DIV_BITS) begin : g_bad_width
      $error("rtc_prediv: PRE_W too narrow for divider select range");
   end

   logic [PRE_W-1:0] div_mask;
   logic             at_cmp;
   logic             div_hit;

   // thermometer mask: bit i set when selected divide exponent exceeds i
   for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign div_mask[i] = (32'(div_sel) > i);
   end

   assign at_cmp   = (pre_q == cmp_lo);
   assign div_hit  = ((pre_q & div_mask) == div_mask);
   assign main_tick = adv && (match_mode ? at_cmp : div_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (ld) begin
         pre_q <= ld_val;
      end else if (adv) begin
         if (wrap_en && at_cmp) pre_q <= '0;
         else                   pre_q <= pre_q + 1'b1;
      end
   end

endmodule

// File: rtl/rtc_main_cnt.sv
module rtc_main_cnt #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wrap_en,
   input  logic [CNT_W-1:0] wrap_val,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt_q
);

   if (CNT_W < 2) begin : g_bad_width
      $error("rtc_main_cnt: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ld) begin
         cnt_q <= ld_val;
      end else if (tick) begin
         if (wrap_en && (cnt_q == wrap_val)) cnt_q <= '0;
         else                                cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
   import rtc_timebase_pkg::*;
#(
   parameter int PRE_W  = 15,
   parameter int CNT_W  = 32,
   parameter int COMB_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run_en,
   input  logic                 tick_en,
   input  logic                 dbg_halt,
   input  logic                 cfg_wr,
   input  logic [DIV_SEL_W-1:0] cfg_div_sel,
   input  logic                 cfg_match_mode,
   input  logic                 cfg_pre_wrap,
   input  logic                 cfg_cnt_wrap,
   input  logic                 cfg_dbg_run,
   input  logic [CNT_W-1:0]     cmp0,
   input  logic [CNT_W-1:0]     cmp1,
   input  logic                 pre_ld,
   input  logic [PRE_W-1:0]     pre_ld_val,
   input  logic                 cnt_ld,
   input  logic [CNT_W-1:0]     cnt_ld_val,
   output logic [PRE_W-1:0]     pre_q,
   output logic [CNT_W-1:0]     cnt_q,
   output logic [COMB_W-1:0]    comb_q,
   output logic                 cnt_tick
);

   localparam int HI_W = COMB_W - PRE_W;

   if (HI_W < 1 || HI_W > CNT_W) begin : g_bad_comb
      $error("rtc_timebase: COMB_W inconsistent with PRE_W and CNT_W");
   end
   if (CNT_W < PRE_W) begin : g_bad_cmp
      $error("rtc_timebase: CNT_W must cover the pre-counter compare field");
   end

   tb_cfg_t cfg_q;
   logic    adv;
   logic    main_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
      end else if (cfg_wr) begin
         cfg_q <= '{
            div_sel:    cfg_div_sel,
            match_mode: cfg_match_mode,
            pre_wrap:   cfg_pre_wrap,
            cnt_wrap:   cfg_cnt_wrap,
            dbg_run:    cfg_dbg_run
         };
      end
   end

   logic cfg_pre_wrap_q;
   logic cfg_cnt_wrap_q;
   logic cfg_dbg_run_q;
   assign cfg_pre_wrap_q = cfg_q.pre_wrap;
   assign cfg_cnt_wrap_q = cfg_q.cnt_wrap;
   assign cfg_dbg_run_q  = cfg_q.dbg_run;

   assign adv = run_en && tick_en && (!dbg_halt || cfg_dbg_run_q);

   rtc_prediv #(
      .PRE_W (PRE_W),
      .SEL_W (DIV_SEL_W)
   ) u_prediv (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (adv),
      .div_sel    (cfg_q.div_sel),
      .match_mode (cfg_q.match_mode),
      .wrap_en    (cfg_pre_wrap_q),
      .cmp_lo     (cmp0[PRE_W-1:0]),
      .ld         (pre_ld),
      .ld_val     (pre_ld_val),
      .pre_q      (pre_q),
      .main_tick  (main_tick)
   );

   rtc_main_cnt #(
      .CNT_W (CNT_W)
   ) u_main (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (main_tick),
      .wrap_en  (cfg_cnt_wrap_q),
      .wrap_val (cmp1),
      .ld       (cnt_ld),
      .ld_val   (cnt_ld_val),
      .cnt_q    (cnt_q)
   );

   assign cnt_tick = main_tick;
   assign comb_q   = {cnt_q[HI_W-1:0], pre_q};

endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk #(
   parameter int PRE_W = 15,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             adv,
   input logic             run_en,
   input logic             dbg_halt,
   input logic             dbg_run,
   input logic             pre_wrap,
   input logic             cnt_wrap,
   input logic [CNT_W-1:0] cmp0,
   input logic [CNT_W-1:0] cmp1,
   input logic             pre_ld,
   input logic [PRE_W-1:0] pre_ld_val,
   input logic             cnt_ld,
   input logic [CNT_W-1:0] cnt_ld_val,
   input logic [PRE_W-1:0] pre_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             cnt_tick
);

   assert_pre_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_wrap && adv && !pre_ld && pre_q == cmp0[PRE_W-1:0]) |=> (pre_q == '0));

   assert_cnt_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wrap && cnt_tick && !cnt_ld && cnt_q == cmp1) |=> (cnt_q == '0));

   assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !pre_ld && !cnt_ld) |=> ($stable(pre_q) && $stable(cnt_q)));

   assert_dbg_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_halt && !dbg_run && !pre_ld && !cnt_ld) |=> ($stable(pre_q) && $stable(cnt_q)));

   assert_pre_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pre_ld |=> (pre_q == $past(pre_ld_val)));

   assert_cnt_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ld |=> (cnt_q == $past(cnt_ld_val)));

   assert_tick_inc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_tick && !cnt_ld && !(cnt_wrap && cnt_q == cmp1))
         |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_tick && !cnt_ld) |=> $stable(cnt_q));

endmodule

bind rtc_timebase rtc_timebase_chk #(
   .PRE_W (PRE_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .adv        (adv),
   .run_en     (run_en),
   .dbg_halt   (dbg_halt),
   .dbg_run    (cfg_dbg_run_q),
   .pre_wrap   (cfg_pre_wrap_q),
   .cnt_wrap   (cfg_cnt_wrap_q),
   .cmp0       (cmp0),
   .cmp1       (cmp1),
   .pre_ld     (pre_ld),
   .pre_ld_val (pre_ld_val),
   .cnt_ld     (cnt_ld),
   .cnt_ld_val (cnt_ld_val),
   .pre_q      (pre_q),
   .cnt_q      (cnt_q),
   .cnt_tick   (cnt_tick)
);

// File: tb/sim_rtc_timebase.sv
module sim_rtc_timebase;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        tick_en = 1'b0;
   logic        dbg_halt = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_div_sel = 4'd0;
   logic        cfg_match_mode = 1'b0;
   logic        cfg_pre_wrap = 1'b0;
   logic        cfg_cnt_wrap = 1'b0;
   logic        cfg_dbg_run = 1'b0;
   logic [31:0] cmp0 = '0;
   logic [31:0] cmp1 = '0;
   logic        pre_ld = 1'b0;
   logic [14:0] pre_ld_val = '0;
   logic        cnt_ld = 1'b0;
   logic [31:0] cnt_ld_val = '0;
   logic [14:0] pre_q;
   logic [31:0] cnt_q;
   logic [31:0] comb_q;
   logic        cnt_tick;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   rtc_timebase u0 (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick_en(tick_en),
      .dbg_halt(dbg_halt), .cfg_wr(cfg_wr), .cfg_div_sel(cfg_div_sel),
      .cfg_match_mode(cfg_match_mode), .cfg_pre_wrap(cfg_pre_wrap),
      .cfg_cnt_wrap(cfg_cnt_wrap), .cfg_dbg_run(cfg_dbg_run),
      .cmp0(cmp0), .cmp1(cmp1), .pre_ld(pre_ld), .pre_ld_val(pre_ld_val),
      .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val), .pre_q(pre_q),
      .cnt_q(cnt_q), .comb_q(comb_q), .cnt_tick(cnt_tick)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic chk_pc(string req, logic [14:0] ep, logic [31:0] ec);
      chk({req, " pre"}, 32'(pre_q), 32'(ep));
      chk({req, " cnt"}, cnt_q, ec);
   endtask

   task automatic adv(int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic load(logic [14:0] p, logic [31:0] c);
      pre_ld = 1'b1; pre_ld_val = p;
      cnt_ld = 1'b1; cnt_ld_val = c;
      @(negedge clk);
      pre_ld = 1'b0; cnt_ld = 1'b0;
   endtask

   task automatic cfg(logic [3:0] k, logic mm, logic pw, logic cw, logic dr);
      cfg_div_sel = k; cfg_match_mode = mm; cfg_pre_wrap = pw;
      cfg_cnt_wrap = cw; cfg_dbg_run = dr;
      cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic t_reset;
      chk_pc("R1 reset", 15'd0, 32'd0);
      chk("R1 reset comb", comb_q, 32'd0);
      chk("R1 reset tick", 32'(cnt_tick), 32'd0);
   endtask

   task automatic t_default_div;
      run_en = 1'b1;
      adv(31);
      chk_pc("R1 R2 default div32 before", 15'd31, 32'd0);
      tick_en = 1'b1;
      #1;
      chk("R10 tick strobe", 32'(cnt_tick), 32'd1);
      @(negedge clk);
      tick_en = 1'b0;
      #1;
      chk_pc("R1 R2 default div32 after", 15'd32, 32'd1);
      chk("R10 tick one cycle", 32'(cnt_tick), 32'd0);
   endtask

   task automatic t_div_sel;
      cfg(4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      load(15'd0, 32'd0);
      adv(5);
      chk_pc("R2 div1", 15'd5, 32'd5);
      cfg(4'd3, 1'b0, 1'b0, 1'b0, 1'b0);
      load(15'd0, 32'd0);
      adv(23);
      chk_pc("R2 div8 partial", 15'd23, 32'd2);
      adv(1);
      chk_pc("R2 div8", 15'd24, 32'd3);
      cfg(4'd15, 1'b0, 1'b0, 1'b0, 1'b0);
      load(15'd32766, 32'd9);
      adv(1);
      chk_pc("R2 div32768 no tick", 15'd32767, 32'd9);
      adv(1);
      chk_pc("R2 div32768 tick", 15'd0, 32'd10);
   endtask

   task automatic t_match;
      cmp0 = 32'hABCD_0005;
      cfg(4'd0, 1'b1, 1'b0, 1'b0, 1'b0);
      load(15'd0, 32'd0);
      adv(5);
      chk_pc("R3 match before", 15'd5, 32'd0);
      adv(1);
      chk_pc("R3 match hit", 15'd6, 32'd1);
      cfg(4'd0, 1'b1, 1'b1, 1'b0, 1'b0);
      load(15'd0, 32'd0);
      adv(6);
      chk_pc("R4 pre wrap once", 15'd0, 32'd1);
      adv(6);
      chk_pc("R3 R4 pre wrap twice", 15'd0, 32'd2);
   endtask

   task automatic t_cnt_wrap;
      cmp1 = 32'd3;
      cfg(4'd0, 1'b0, 1'b0, 1'b1, 1'b0);
      load(15'd0, 32'd0);
      adv(3);
      chk("R5 reach cmp1", cnt_q, 32'd3);
      adv(1);
      chk("R5 wrap", cnt_q, 32'd0);
      adv(1);
      chk("R5 after wrap", cnt_q, 32'd1);
   endtask

   task automatic t_comb;
      run_en = 1'b0;
      load(15'h1234, 32'h0003_FFFF);
      chk("R6 comb", comb_q, 32'hFFFF_9234);
      load(15'h7FFF, 32'h0002_0000);
      chk("R6 comb upper dropped", comb_q, 32'h0000_7FFF);
      run_en = 1'b1;
   endtask

   task automatic t_debug;
      cfg(4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      load(15'd0, 32'd0);
      dbg_halt = 1'b1;
      adv(5);
      chk_pc("R7 halt freeze", 15'd0, 32'd0);
      cfg(4'd0, 1'b0, 1'b0, 1'b0, 1'b1);
      adv(3);
      chk_pc("R7 halt run", 15'd3, 32'd3);
      dbg_halt = 1'b0;
   endtask

   task automatic t_hold;
      cfg(4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      load(15'd7, 32'd70);
      run_en = 1'b0;
      adv(6);
      chk_pc("R8 run_en low", 15'd7, 32'd70);
      run_en = 1'b1;
      repeat (5) @(negedge clk);
      chk_pc("R8 tick_en low", 15'd7, 32'd70);
   endtask

   task automatic t_load_prio;
      cfg(4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      load(15'd0, 32'd0);
      tick_en = 1'b1;
      load(15'd100, 32'd500);
      tick_en = 1'b0;
      chk_pc("R9 load over inc", 15'd100, 32'd500);
      adv(1);
      chk_pc("R9 after load", 15'd101, 32'd501);
   endtask

   task automatic t_cfg_gate;
      cfg(4'd3, 1'b0, 1'b0, 1'b0, 1'b0);
      load(15'd0, 32'd0);
      cfg_div_sel = 4'd0;
      cfg_match_mode = 1'b1;
      adv(1);
      chk_pc("R11 no cfg_wr", 15'd1, 32'd0);
      adv(7);
      chk_pc("R11 old div kept", 15'd8, 32'd1);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default_div();
      t_div_sel();
      t_match();
      t_cnt_wrap();
      t_comb();
      t_debug();
      t_hold();
      t_load_prio();
      t_cfg_gate();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule